// File: doc/BRIEF.md
# Receive Aggregation Window Closer

This block watches one receive endpoint's aggregation window and decides when that window must close. Each accepted packet is reported by an append strobe that carries the packet's byte length and an end-of-frame mark. The block keeps a byte total, a packet count and a tick count for the open window. It raises a one-cycle close strobe with a reason code as soon as any configured limit, an end-of-frame, a forced close or pass-through mode calls for it.

The window timer advances only on ticks from one of two external pulse sources: a fine one (100 us period) or a coarse one (1 ms period). A single configuration bit picks the source. All limits arrive in one 32-bit configuration word through a plain write port. A write that has the force bit set also asks for an immediate close of the open window. The append port carries no ready signal: the block never stalls an append, and each append is counted in the cycle it is presented.

Top module: `agw_window_closer`

## Requirements
- R1: After reset, close_o and reason_o are 0, the window is empty, and the configuration word is all zero, which selects pass-through mode.
- R2: Soft byte limit (hard bit 24 = 0). The byte limit in bits [10:5] is in units of 1024 bytes. The window closes with reason 1 (byte) after the append that makes the byte total strictly greater than limit*1024. A total equal to the threshold does not close the window, and the crossing packet is counted whole.
- R3: Hard byte limit (bit 24 = 1). The window closes with reason 1 after the append that makes the byte total greater than or equal to limit*1024.
- R4: Packet limit in bits [21:16]. The window closes with reason 3 (packet) after the append that brings the packet count to the limit. A limit of 0 never closes a window by packet count.
- R5: Time limit in bits [15:11]. Ticks are counted only in cycles after the window's first append. A tick that arrives with the first append is not counted. The window closes with reason 2 (time) in the cycle whose tick brings the count to the limit. A limit of 0 disables the timer.
- R6: Select bit 25 picks the tick source: 0 counts tick_fine only and 1 counts tick_coarse only. Ticks from the other source have no effect.
- R7: With the end-of-frame enable bit 22 set, an append with pkt_eof high closes the window with reason 4 (eof). With bit 22 clear, pkt_eof has no effect.
- R8: A configuration write with bit 23 set closes an open window with reason 5 (force). This includes a window opened by an append in that same cycle. A forced close of an empty window produces no strobe. Bit 23 is not stored.
- R9: When several conditions hold in one cycle, the reason reported follows this priority: force (5) > eof (4) > byte (1) > packet (3) > time (2).
- R10: Every close clears the byte, packet and tick counts, and the closing cycle's append belongs to the closed window. The next append opens a fresh window.
- R11: When mode bits [1:0] are not 2'b01 (aggregate), every append closes at once with reason 6 (pass), including appends on back-to-back cycles.
- R12: close_o is high for exactly one cycle per close, in the cycle after the clock edge that samples the causing event. reason_o is 0 whenever close_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 32 | Configuration word. Mode [1:0]; [4:2] ignored; byte limit in KB [10:5]; time limit [15:11]; packet limit [21:16]; eof enable [22]; force [23]; hard byte [24]; tick select [25] |
| pkt_valid | input | 1 | Append strobe, one packet per cycle |
| pkt_len | input | LEN_W | Byte length of the appended packet |
| pkt_eof | input | 1 | Appended packet ends a frame |
| tick_fine | input | 1 | Pulse from the 100 us generator |
| tick_coarse | input | 1 | Pulse from the 1 ms generator |
| close_o | output | 1 | One-cycle window close strobe |
| reason_o | output | 3 | Close reason: 1 byte, 2 time, 3 packet, 4 eof, 5 force, 6 pass, 0 none |

## Verification
A stale count that survives a close shows up within a single window: the next window's byte or packet limit trips early, and the close strobe appears one append too soon. A tick counter that ran while the window was empty, or that counted the unselected source, moves the time close earlier by whole ticks. A priority or reason error changes reason_o in the very cycle of the strobe. Because the scoreboard ties every expected close to an exact cycle, a strobe one cycle late or early is reported at once.

// File: rtl/agw_pkg.sv
package agw_pkg;
  localparam int CFG_W     = 32;
  localparam int MODE_W    = 2;
  localparam int BLIM_W    = 6;
  localparam int TLIM_W    = 5;
  localparam int PLIM_W    = 6;
  localparam int KB_SHIFT  = 10;

  localparam int MODE_LSB  = 0;
  localparam int BLIM_LSB  = 5;
  localparam int TLIM_LSB  = 11;
  localparam int PLIM_LSB  = 16;
  localparam int EOFEN_BIT = 22;
  localparam int FORCE_BIT = 23;
  localparam int HARD_BIT  = 24;
  localparam int TSEL_BIT  = 25;

  localparam logic [MODE_W-1:0] MODE_AGG = 2'b01;

  typedef enum logic [2:0] {
    RSN_NONE  = 3'd0,
    RSN_BYTE  = 3'd1,
    RSN_TIME  = 3'd2,
    RSN_PKT   = 3'd3,
    RSN_EOF   = 3'd4,
    RSN_FORCE = 3'd5,
    RSN_PASS  = 3'd6
  } reason_e;

  typedef struct packed {
    logic [MODE_W-1:0] mode;
    logic [BLIM_W-1:0] byte_kb;
    logic [TLIM_W-1:0] tick_lim;
    logic [PLIM_W-1:0] pkt_lim;
    logic              eof_en;
    logic              hard;
    logic              coarse;
  } cfg_t;
endpackage

// File: rtl/agw_cfg_reg.sv
module agw_cfg_reg
  import agw_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [CFG_W-1:0] wdata,
  output cfg_t             cfg_q,
  output logic             force_req
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else if (we) begin
      cfg_q.mode     <= wdata[MODE_LSB +: MODE_W];
      cfg_q.byte_kb  <= wdata[BLIM_LSB +: BLIM_W];
      cfg_q.tick_lim <= wdata[TLIM_LSB +: TLIM_W];
      cfg_q.pkt_lim  <= wdata[PLIM_LSB +: PLIM_W];
      cfg_q.eof_en   <= wdata[EOFEN_BIT];
      cfg_q.hard     <= wdata[HARD_BIT];
      cfg_q.coarse   <= wdata[TSEL_BIT];
    end
  end

  // force is a request carried by the write itself, never held
  assign force_req = we & wdata[FORCE_BIT];
endmodule

// File: rtl/agw_tick_sel.sv
module agw_tick_sel #(
  parameter int NSRC = 2,
  localparam int SEL_W = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic [NSRC-1:0]  src,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  logic [NSRC-1:0] hit;

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    assign hit[i] = src[i] && (sel == SEL_W'(i));
  end

  assign tick = |hit;
endmodule

// File: rtl/agw_window_cnt.sv
module agw_window_cnt #(
  parameter int LEN_W  = 16,
  parameter int BYTE_W = 18,
  parameter int PCNT_W = 6,
  parameter int TCNT_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              app,
  input  logic [LEN_W-1:0]  len,
  input  logic              tick,
  input  logic              clear,
  output logic [BYTE_W-1:0] byte_q,
  output logic [PCNT_W-1:0] pkt_q,
  output logic              open_q,
  output logic [BYTE_W-1:0] bytes_sum,
  output logic [PCNT_W-1:0] pkts_sum,
  output logic [TCNT_W-1:0] ticks_sum,
  output logic              open_sum
);
  localparam logic [PCNT_W-1:0] PMAX = '1;
  localparam logic [TCNT_W-1:0] TMAX = '1;

  logic [TCNT_W-1:0] tick_q;
  logic [BYTE_W-1:0] len_ext;

  assign len_ext = {{(BYTE_W-LEN_W){1'b0}}, len};

  always_comb begin
    bytes_sum = app ? byte_q + len_ext : byte_q;
    pkts_sum  = (app && pkt_q != PMAX) ? pkt_q + 1'b1 : pkt_q;
    // the timer runs only once the window already holds a packet
    ticks_sum = (open_q && tick && tick_q != TMAX) ? tick_q + 1'b1 : tick_q;
    open_sum  = open_q | app;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      byte_q <= '0;
      pkt_q  <= '0;
      tick_q <= '0;
      open_q <= 1'b0;
    end else begin
      byte_q <= bytes_sum;
      pkt_q  <= pkts_sum;
      tick_q <= ticks_sum;
      open_q <= open_sum;
    end
  end
endmodule

// File: rtl/agw_close_arb.sv
module agw_close_arb
  import agw_pkg::*;
#(
  parameter int BYTE_W = 18,
  parameter int PCNT_W = 6,
  parameter int TCNT_W = 5
) (
  input  cfg_t              cfg,
  input  logic              app,
  input  logic              eof,
  input  logic              force_req,
  input  logic              open_q,
  input  logic              open_sum,
  input  logic [BYTE_W-1:0] bytes_sum,
  input  logic [PCNT_W-1:0] pkts_sum,
  input  logic [TCNT_W-1:0] ticks_sum,
  output logic              close_now,
  output reason_e           reason
);
  logic [BYTE_W-1:0] thr;
  logic agg, hit_force, hit_pass, hit_eof, hit_byte, hit_pkt, hit_time;

  always_comb begin
    thr       = BYTE_W'({cfg.byte_kb, {KB_SHIFT{1'b0}}});
    agg       = (cfg.mode == MODE_AGG);
    hit_force = force_req && open_sum;
    hit_pass  = !agg && app;
    hit_eof   = agg && app && eof && cfg.eof_en;
    hit_byte  = agg && app && (cfg.hard ? (bytes_sum >= thr) : (bytes_sum > thr));
    hit_pkt   = agg && app && (cfg.pkt_lim != '0) &&
                (pkts_sum >= PCNT_W'(cfg.pkt_lim));
    hit_time  = agg && open_q && (cfg.tick_lim != '0) &&
                (ticks_sum >= TCNT_W'(cfg.tick_lim));

    if (hit_force)     reason = RSN_FORCE;
    else if (hit_pass) reason = RSN_PASS;
    else if (hit_eof)  reason = RSN_EOF;
    else if (hit_byte) reason = RSN_BYTE;
    else if (hit_pkt)  reason = RSN_PKT;
    else if (hit_time) reason = RSN_TIME;
    else               reason = RSN_NONE;

    close_now = (reason != RSN_NONE);
  end
endmodule

// File: rtl/agw_window_closer.sv
module agw_window_closer
  import agw_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [31:0]      cfg_wdata,
  input  logic             pkt_valid,
  input  logic [LEN_W-1:0] pkt_len,
  input  logic             pkt_eof,
  input  logic             tick_fine,
  input  logic             tick_coarse,
  output logic             close_o,
  output logic [2:0]       reason_o
);
  localparam int KB_BITS = BLIM_W + KB_SHIFT;
  localparam int BYTE_W  = ((LEN_W > KB_BITS) ? LEN_W : KB_BITS) + 1;
  localparam int PCNT_W  = PLIM_W;
  localparam int TCNT_W  = TLIM_W;

  cfg_t              cfg_q;
  logic              force_req;
  logic              tick;
  logic [BYTE_W-1:0] byte_q, bytes_sum;
  logic [PCNT_W-1:0] pkt_q, pkts_sum;
  logic [TCNT_W-1:0] ticks_sum;
  logic              open_q, open_sum;
  logic              close_now;
  reason_e           reason;

  agw_cfg_reg u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .we        (cfg_we),
    .wdata     (cfg_wdata),
    .cfg_q     (cfg_q),
    .force_req (force_req)
  );

  agw_tick_sel #(.NSRC(2)) u_tick (
    .src  ({tick_coarse, tick_fine}),
    .sel  (cfg_q.coarse),
    .tick (tick)
  );

  agw_window_cnt #(
    .LEN_W(LEN_W), .BYTE_W(BYTE_W), .PCNT_W(PCNT_W), .TCNT_W(TCNT_W)
  ) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .app       (pkt_valid),
    .len       (pkt_len),
    .tick      (tick),
    .clear     (close_now),
    .byte_q    (byte_q),
    .pkt_q     (pkt_q),
    .open_q    (open_q),
    .bytes_sum (bytes_sum),
    .pkts_sum  (pkts_sum),
    .ticks_sum (ticks_sum),
    .open_sum  (open_sum)
  );

  agw_close_arb #(
    .BYTE_W(BYTE_W), .PCNT_W(PCNT_W), .TCNT_W(TCNT_W)
  ) u_arb (
    .cfg       (cfg_q),
    .app       (pkt_valid),
    .eof       (pkt_eof),
    .force_req (force_req),
    .open_q    (open_q),
    .open_sum  (open_sum),
    .bytes_sum (bytes_sum),
    .pkts_sum  (pkts_sum),
    .ticks_sum (ticks_sum),
    .close_now (close_now),
    .reason    (reason)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      close_o  <= 1'b0;
      reason_o <= '0;
    end else begin
      close_o  <= close_now;
      reason_o <= close_now ? reason : RSN_NONE;
    end
  end
endmodule

// File: rtl/agw_checker.sv
module agw_checker
  import agw_pkg::*;
#(
  parameter int BYTE_W = 18,
  parameter int PCNT_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pkt_valid,
  input logic              pkt_eof,
  input cfg_t              cfg,
  input logic              force_req,
  input logic              open_q,
  input logic [BYTE_W-1:0] byte_q,
  input logic [PCNT_W-1:0] pkt_q,
  input logic              close_o,
  input logic [2:0]        reason_o
);
  AST_QUIET_REASON: assert property (@(posedge clk) disable iff (!rst_n)
    !close_o |-> reason_o == 3'd0);                                           // R12
  AST_STROBE_HAS_REASON: assert property (@(posedge clk) disable iff (!rst_n)
    close_o |-> reason_o != 3'd0);                                            // R12
  AST_FORCE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (force_req && pkt_valid) |=> (close_o && reason_o == 3'd5));              // R8
  AST_EOF_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.mode == MODE_AGG && cfg.eof_en && pkt_valid && pkt_eof && !force_req)
      |=> (close_o && reason_o == 3'd4));                                     // R7
  AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.mode != MODE_AGG && pkt_valid && !force_req)
      |=> (close_o && reason_o == 3'd6));                                     // R11
  AST_EMPTY_STAYS_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!open_q && !pkt_valid) |=> !close_o);                                    // R8
  AST_CLEAR_ON_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
    close_o |-> (byte_q == '0 && pkt_q == '0 && !open_q));                    // R10
endmodule

bind agw_window_closer agw_checker #(.BYTE_W(BYTE_W), .PCNT_W(PCNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .pkt_valid (pkt_valid),
  .pkt_eof   (pkt_eof),
  .cfg       (cfg_q),
  .force_req (force_req),
  .open_q    (open_q),
  .byte_q    (byte_q),
  .pkt_q     (pkt_q),
  .close_o   (close_o),
  .reason_o  (reason_o)
);

// File: tb/agw_window_closer_tb.sv
module agw_window_closer_tb_top;
  localparam logic [2:0] X_BYTE = 3'd1, X_TIME = 3'd2, X_PKT = 3'd3,
                         X_EOF = 3'd4, X_FORCE = 3'd5, X_PASS = 3'd6, X_NONE = 3'd0;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic        pkt_valid = 1'b0;
  logic [15:0] pkt_len = '0;
  logic        pkt_eof = 1'b0;
  logic        tick_fine = 1'b0;
  logic        tick_coarse = 1'b0;
  logic        close_o;
  logic [2:0]  reason_o;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  bit done = 1'b0;

  typedef struct { int at; logic [2:0] rsn; } exp_t;
  exp_t expq[$];

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  agw_window_closer dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .pkt_valid(pkt_valid), .pkt_len(pkt_len), .pkt_eof(pkt_eof),
    .tick_fine(tick_fine), .tick_coarse(tick_coarse),
    .close_o(close_o), .reason_o(reason_o)
  );

  function automatic logic [31:0] mk(input logic [1:0] mode, input int kb, input int tl,
                                     input int pl, input bit eofen, input bit frc,
                                     input bit hard, input bit coarse);
    logic [31:0] w = '0;
    w[1:0]   = mode;
    w[10:5]  = kb[5:0];
    w[15:11] = tl[4:0];
    w[21:16] = pl[5:0];
    w[22] = eofen; w[23] = frc; w[24] = hard; w[25] = coarse;
    return w;
  endfunction

  // driver: one cycle of stimulus, with the close it must cause (if any)
  task automatic step(input bit v, input int len, input bit e, input bit we,
                      input logic [31:0] wd, input bit tf, input bit tc,
                      input logic [2:0] exp_rsn);
    @(negedge clk);
    pkt_valid = v; pkt_len = len[15:0]; pkt_eof = e;
    cfg_we = we; cfg_wdata = wd; tick_fine = tf; tick_coarse = tc;
    if (exp_rsn != X_NONE) expq.push_back('{at: cyc + 1, rsn: exp_rsn});
  endtask

  task automatic app(input int len, input bit e, input logic [2:0] r);
    step(1'b1, len, e, 1'b0, '0, 1'b0, 1'b0, r);
  endtask

  task automatic wr(input logic [31:0] wd, input logic [2:0] r);
    step(1'b0, 0, 1'b0, 1'b1, wd, 1'b0, 1'b0, r);
  endtask

  task automatic tk(input bit tf, input bit tc, input logic [2:0] r);
    step(1'b0, 0, 1'b0, 1'b0, '0, tf, tc, r);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 0, 1'b0, 1'b0, '0, 1'b0, 1'b0, X_NONE);
  endtask

  // monitor: every close must match the head of the queue in the expected cycle
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (close_o) begin
        checks++;
        if (expq.size() == 0 || expq[0].at != cyc) begin
          fails++;
          $display("FAIL R12 unexpected close at cycle %0d reason actual %0d expected none",
                   cyc, reason_o);
        end else begin
          if (reason_o != expq[0].rsn) begin
            fails++;
            $display("FAIL R9 reason at cycle %0d actual %0d expected %0d",
                     cyc, reason_o, expq[0].rsn);
          end
          void'(expq.pop_front());
        end
      end else if (expq.size() != 0 && expq[0].at <= cyc) begin
        checks++; fails++;
        $display("FAIL R12 missing close at cycle %0d actual none expected reason %0d",
                 cyc, expq[0].rsn);
        void'(expq.pop_front());
      end
    end
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (close_o !== 1'b0 || reason_o !== 3'd0) begin
      fails++;
      $display("FAIL R1 reset outputs actual %b/%0d expected 0/0", close_o, reason_o);
    end
    rst_n = 1'b1;

    // R1 R11: reset config is pass-through, back-to-back appends each close
    app(100, 1'b0, X_PASS);
    app(200, 1'b0, X_PASS);
    idle(1);

    // R2 soft byte limit 1 KB; equal does not close, crossing does; R10 fresh window
    wr(mk(2'b01, 1, 0, 0, 0, 0, 0, 0), X_NONE);
    app(1000, 1'b0, X_NONE);
    app(24, 1'b0, X_NONE);
    app(1, 1'b0, X_BYTE);
    app(1014, 1'b0, X_NONE);
    app(10, 1'b0, X_NONE);
    app(1, 1'b0, X_BYTE);

    // R3 hard byte limit: equal closes
    wr(mk(2'b01, 1, 0, 0, 0, 0, 1, 0), X_NONE);
    app(1024, 1'b0, X_BYTE);
    app(1023, 1'b0, X_NONE);
    wr(mk(2'b01, 1, 0, 0, 0, 1, 1, 0), X_FORCE);            // R8

    // R4 packet limit 3, then limit 0 unlimited
    wr(mk(2'b01, 63, 0, 3, 0, 0, 0, 0), X_NONE);
    app(10, 1'b0, X_NONE);
    app(10, 1'b0, X_NONE);
    app(10, 1'b0, X_PKT);
    wr(mk(2'b01, 63, 0, 0, 0, 0, 0, 0), X_NONE);
    for (int i = 0; i < 5; i++) app(10, 1'b0, X_NONE);
    wr(mk(2'b01, 63, 0, 0, 0, 1, 0, 0), X_FORCE);            // R8 open window
    wr(mk(2'b01, 63, 0, 0, 0, 1, 0, 0), X_NONE);             // R8 empty window
    idle(1);

    // R5 R6 fine ticks, limit 3
    wr(mk(2'b01, 63, 3, 0, 0, 0, 0, 0), X_NONE);
    tk(1'b1, 1'b0, X_NONE);                                  // empty window: not counted
    step(1'b1, 10, 1'b0, 1'b0, '0, 1'b1, 1'b0, X_NONE);       // tick with first append: not counted
    tk(1'b0, 1'b1, X_NONE);                                  // coarse ignored
    tk(1'b0, 1'b1, X_NONE);
    tk(1'b1, 1'b0, X_NONE);
    tk(1'b1, 1'b0, X_NONE);
    tk(1'b1, 1'b0, X_TIME);
    // R6 coarse ticks, limit 2
    wr(mk(2'b01, 63, 2, 0, 0, 0, 0, 1), X_NONE);
    app(10, 1'b0, X_NONE);
    tk(1'b1, 1'b0, X_NONE);
    tk(1'b1, 1'b0, X_NONE);
    tk(1'b0, 1'b1, X_NONE);
    tk(1'b0, 1'b1, X_TIME);
    // R5 limit 0 disables timer
    wr(mk(2'b01, 63, 0, 0, 0, 0, 0, 0), X_NONE);
    app(10, 1'b0, X_NONE);
    for (int i = 0; i < 5; i++) tk(1'b1, 1'b1, X_NONE);
    wr(mk(2'b01, 63, 0, 0, 0, 1, 0, 0), X_FORCE);

    // R7 end-of-frame enabled and disabled
    wr(mk(2'b01, 63, 0, 0, 1, 0, 0, 0), X_NONE);
    app(10, 1'b1, X_EOF);
    wr(mk(2'b01, 63, 0, 0, 0, 0, 0, 0), X_NONE);
    app(10, 1'b1, X_NONE);
    idle(2);
    wr(mk(2'b01, 63, 0, 0, 0, 1, 0, 0), X_FORCE);

    // R9 priorities
    wr(mk(2'b01, 1, 0, 0, 1, 0, 0, 0), X_NONE);
    app(2000, 1'b1, X_EOF);                                  // eof over byte
    step(1'b1, 10, 1'b1, 1'b1, mk(2'b01, 1, 0, 0, 1, 1, 0, 0), 1'b0, 1'b0, X_FORCE); // force over eof
    wr(mk(2'b01, 1, 0, 2, 0, 0, 0, 0), X_NONE);
    app(100, 1'b0, X_NONE);
    app(2000, 1'b0, X_BYTE);                                 // byte over packet
    wr(mk(2'b01, 63, 1, 2, 0, 0, 0, 0), X_NONE);
    app(10, 1'b0, X_NONE);
    step(1'b1, 10, 1'b0, 1'b0, '0, 1'b1, 1'b0, X_PKT);        // packet over time

    idle(3);
    if (expq.size() != 0) begin
      checks++; fails++;
      $display("FAIL R12 closes outstanding actual %0d expected 0", expq.size());
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule